// File: doc/BRIEF.md
# In-Order Issue Group Dependence Checker

This block sits at the decode stage of an in-order pipeline that can issue up to `WIDTH` instructions per cycle (2 to 4). Every cycle it sees a window of decoded slots, oldest first. Each slot carries a valid bit, two source register numbers, a destination register number, a flag saying the destination is really written, a load flag and a memory-operation flag (set for loads and stores). The block returns the longest run of slots, starting from the oldest, that can issue together in that cycle.

The group ends at the first slot with any of these problems: it is invalid, it reads a register that an older slot in the same window writes, it reads a register loaded by a load issued in the previous cycle, or it is a second memory operation. Every slot from that point on stalls. The upstream stage keeps the stalled slots and presents them again as the oldest slots in the next cycle. The only state inside the block is the set of destinations of the loads that were granted in the previous cycle.

Top module: `issue_group_check`

## Requirements
- R1: When the window holds only valid, non-memory slots whose registers do not overlap, all of them issue in the same cycle.
- R2: A slot that reads, through either source, the nonzero destination of an older valid slot with its write flag set does not issue, and no younger slot issues either.
- R3: Register 0 never creates a dependence, whether within the window or against a previous load.
- R4: An older slot whose write flag is clear creates no dependence, even when its destination field matches a younger source.
- R5: A slot that reads the nonzero destination of a load granted in the previous cycle stalls. One cycle later the same slot can issue, provided no load was granted in between.
- R6: At most one memory operation issues per cycle. The second memory slot in the window stalls, and so does everything younger.
- R7: Bit i of `issueMask` refers to slot i, with slot 0 the oldest. The mask is always a contiguous run of ones starting at bit 0. An invalid slot ends the run.
- R8: `stall` is high exactly when some valid slot does not issue.
- R9: Reset clears the record of previous-cycle loads, so no slot stalls on a load granted before reset.
- R10: A valid slot 0 always issues unless it has a load-use hazard against the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotValid | input | WIDTH | Slot holds an instruction (bit 0 = oldest) |
| slotWrites | input | WIDTH | Slot writes its destination register |
| slotLoad | input | WIDTH | Slot is a load |
| slotMem | input | WIDTH | Slot is a load or store |
| slotSrcA | input | WIDTH*REG_BITS | First source register of each slot, slot i at bits [i*REG_BITS +: REG_BITS] |
| slotSrcB | input | WIDTH*REG_BITS | Second source register of each slot, same packing |
| slotDst | input | WIDTH*REG_BITS | Destination register of each slot, same packing |
| issueMask | output | WIDTH | Slots granted this cycle |
| stall | output | 1 | Some valid slot is held back |

## Verification
The assertions assume that the inputs are steady between clock edges. They also assume that every slot flagged as a load is flagged as a memory operation and has its write flag set, and that stores never set the write flag. The stimulus builds each instruction from one of three kinds (ALU, load, store) that follow these rules. Held slots are re-presented the way an in-order upstream stage would, so the load-use tracking always sees a realistic sequence of granted loads.

// File: rtl/issue_pkg.sv
package issue_pkg;
  // Widest issue group the block is built for.
  localparam int MAX_SLOTS = 4;

  // Strobes from the control side to the datapath side.
  typedef struct packed {
    logic [MAX_SLOTS-1:0] grant;      // slots issued this cycle
    logic                 loadIssued; // some granted slot is a load
  } strobe_t;
endpackage

// File: rtl/issue_hazard_dp.sv
module issue_hazard_dp
  import issue_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int REG_BITS = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [WIDTH-1:0]          slotValid,
  input  logic [WIDTH-1:0]          slotWrites,
  input  logic [WIDTH-1:0]          slotLoad,
  input  logic [WIDTH-1:0]          slotMem,
  input  logic [WIDTH*REG_BITS-1:0] slotSrcA,
  input  logic [WIDTH*REG_BITS-1:0] slotSrcB,
  input  logic [WIDTH*REG_BITS-1:0] slotDst,
  input  strobe_t                   strobe,
  output logic [WIDTH-1:0]          rawHit,
  output logic [WIDTH-1:0]          useHit,
  output logic [WIDTH-1:0]          memHit
);
  logic [WIDTH-1:0][REG_BITS-1:0] srcA, srcB, dst;
  logic [WIDTH-1:0]               producer;
  logic [WIDTH-1:0][REG_BITS-1:0] ldDstQ;
  logic [WIDTH-1:0]               ldVldQ;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_unpack
      assign srcA[g]     = slotSrcA[g*REG_BITS +: REG_BITS];
      assign srcB[g]     = slotSrcB[g*REG_BITS +: REG_BITS];
      assign dst[g]      = slotDst[g*REG_BITS +: REG_BITS];
      assign producer[g] = slotValid[g] & slotWrites[g] & (dst[g] != '0);
    end
  endgenerate

  // Destinations of the loads granted in the previous cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldVldQ <= '0;
      ldDstQ <= '0;
    end else begin
      for (int i = 0; i < WIDTH; i++) begin
        ldVldQ[i] <= strobe.loadIssued & strobe.grant[i] & slotLoad[i] & producer[i];
        ldDstQ[i] <= dst[i];
      end
    end
  end

  // Cross-slot comparators: N*(N-1) source/destination compares.
  always_comb begin
    rawHit = '0;
    useHit = '0;
    memHit = '0;
    for (int i = 1; i < WIDTH; i++) begin
      for (int j = 0; j < i; j++) begin
        if (producer[j] && (dst[j] == srcA[i] || dst[j] == srcB[i])) rawHit[i] = 1'b1;
        if (slotValid[j] && slotMem[j] && slotMem[i]) memHit[i] = 1'b1;
      end
    end
    for (int i = 0; i < WIDTH; i++) begin
      for (int k = 0; k < WIDTH; k++) begin
        if (ldVldQ[k] && (ldDstQ[k] == srcA[i] || ldDstQ[k] == srcB[i])) useHit[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import issue_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] slotValid,
  input  logic [WIDTH-1:0] slotLoad,
  input  logic [WIDTH-1:0] rawHit,
  input  logic [WIDTH-1:0] useHit,
  input  logic [WIDTH-1:0] memHit,
  output logic [WIDTH-1:0] issueMask,
  output logic             stall,
  output strobe_t          strobe
);
  logic open;

  // Grant walks from the oldest slot and closes at the first blocker.
  always_comb begin
    open = 1'b1;
    for (int i = 0; i < WIDTH; i++) begin
      issueMask[i] = open & slotValid[i] & ~rawHit[i] & ~useHit[i] & ~memHit[i];
      open         = issueMask[i];
    end
    stall = |(slotValid & ~issueMask);
    strobe                    = '0;
    strobe.grant[WIDTH-1:0]   = issueMask;
    strobe.loadIssued         = |(issueMask & slotLoad);
  end
endmodule

// File: rtl/issue_group_check.sv
module issue_group_check
  import issue_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int REG_BITS = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [WIDTH-1:0]          slotValid,
  input  logic [WIDTH-1:0]          slotWrites,
  input  logic [WIDTH-1:0]          slotLoad,
  input  logic [WIDTH-1:0]          slotMem,
  input  logic [WIDTH*REG_BITS-1:0] slotSrcA,
  input  logic [WIDTH*REG_BITS-1:0] slotSrcB,
  input  logic [WIDTH*REG_BITS-1:0] slotDst,
  output logic [WIDTH-1:0]          issueMask,
  output logic                      stall
);
  strobe_t          strobe;
  logic [WIDTH-1:0] rawHit, useHit, memHit;

  issue_hazard_dp #(.WIDTH(WIDTH), .REG_BITS(REG_BITS)) u_dp (
    .clk(clk), .rstN(rstN),
    .slotValid(slotValid), .slotWrites(slotWrites), .slotLoad(slotLoad), .slotMem(slotMem),
    .slotSrcA(slotSrcA), .slotSrcB(slotSrcB), .slotDst(slotDst),
    .strobe(strobe), .rawHit(rawHit), .useHit(useHit), .memHit(memHit)
  );

  issue_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .slotValid(slotValid), .slotLoad(slotLoad),
    .rawHit(rawHit), .useHit(useHit), .memHit(memHit),
    .issueMask(issueMask), .stall(stall), .strobe(strobe)
  );
endmodule

// File: rtl/issue_group_check_sva.sv
module issue_group_check_sva #(
  parameter int WIDTH    = 4,
  parameter int REG_BITS = 5
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [WIDTH-1:0]          slotValid,
  input logic [WIDTH-1:0]          slotWrites,
  input logic [WIDTH-1:0]          slotLoad,
  input logic [WIDTH-1:0]          slotMem,
  input logic [WIDTH*REG_BITS-1:0] slotSrcA,
  input logic [WIDTH*REG_BITS-1:0] slotSrcB,
  input logic [WIDTH*REG_BITS-1:0] slotDst,
  input logic [WIDTH-1:0]          issueMask,
  input logic                      stall
);
  logic [WIDTH-1:0]          prevLd;
  logic [WIDTH*REG_BITS-1:0] prevDst;
  logic                      rawIssued, useIssued, headUse;

  // Shadow of the loads seen granted at the ports.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLd  <= '0;
      prevDst <= '0;
    end else begin
      prevLd  <= issueMask & slotLoad & slotWrites;
      prevDst <= slotDst;
    end
  end

  always_comb begin
    rawIssued = 1'b0;
    useIssued = 1'b0;
    headUse   = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      for (int j = 0; j < i; j++) begin
        if (issueMask[i] && issueMask[j] && slotWrites[j] &&
            slotDst[j*REG_BITS +: REG_BITS] != '0 &&
            (slotDst[j*REG_BITS +: REG_BITS] == slotSrcA[i*REG_BITS +: REG_BITS] ||
             slotDst[j*REG_BITS +: REG_BITS] == slotSrcB[i*REG_BITS +: REG_BITS]))
          rawIssued = 1'b1;
      end
      for (int k = 0; k < WIDTH; k++) begin
        if (prevLd[k] && prevDst[k*REG_BITS +: REG_BITS] != '0 &&
            (prevDst[k*REG_BITS +: REG_BITS] == slotSrcA[i*REG_BITS +: REG_BITS] ||
             prevDst[k*REG_BITS +: REG_BITS] == slotSrcB[i*REG_BITS +: REG_BITS])) begin
          if (issueMask[i]) useIssued = 1'b1;
          if (i == 0)       headUse   = 1'b1;
        end
      end
    end
  end

  p_prefix_r7: assert property (@(posedge clk) disable iff (!rstN)
    (((issueMask + 1'b1) & issueMask) == '0) && ((issueMask & ~slotValid) == '0));
  p_mem_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(issueMask & slotMem) <= 1);
  p_no_raw_r2: assert property (@(posedge clk) disable iff (!rstN) !rawIssued);
  p_load_use_r5: assert property (@(posedge clk) disable iff (!rstN) !useIssued);
  p_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid != '0 && !stall) |-> (issueMask == slotValid));
  p_head_r10: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid[0] && !headUse) |-> issueMask[0]);
endmodule

bind issue_group_check issue_group_check_sva #(.WIDTH(WIDTH), .REG_BITS(REG_BITS)) u_sva (.*);

// File: tb/issue_group_check_test.sv
module issue_group_check_test;
  localparam int W  = 4;
  localparam int RB = 5;
  localparam int PROG = 1200;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [W-1:0]  vV, vWr, vLd, vMem;
  logic [W*RB-1:0] vA, vB, vD;
  logic [W-1:0]  issueMask;
  logic          stall;

  bit [RB-1:0] bA[W], bB[W], bD[W];
  bit          bV[W], bWr[W], bLd[W], bMem[W];
  bit [31:0]   prevLoadSet;
  int checks = 0, fails = 0;
  bit done = 0;

  // program for the streaming test
  bit [RB-1:0] pA[PROG], pB[PROG], pD[PROG];
  bit          pWr[PROG], pLd[PROG], pMem[PROG];

  always #4 clk = ~clk;

  issue_group_check #(.WIDTH(W), .REG_BITS(RB)) uut (
    .clk(clk), .rstN(rstN), .slotValid(vV), .slotWrites(vWr), .slotLoad(vLd), .slotMem(vMem),
    .slotSrcA(vA), .slotSrcB(vB), .slotDst(vD), .issueMask(issueMask), .stall(stall)
  );

  task automatic apply();
    for (int i = 0; i < W; i++) begin
      vV[i] = bV[i]; vWr[i] = bWr[i]; vLd[i] = bLd[i]; vMem[i] = bMem[i];
      vA[i*RB +: RB] = bA[i]; vB[i*RB +: RB] = bB[i]; vD[i*RB +: RB] = bD[i];
    end
  endtask

  // Independent, valid ALU slots: sources 20+i / 24+i, destinations 8+i.
  task automatic clearSlots();
    for (int i = 0; i < W; i++) begin
      bV[i] = 1; bWr[i] = 1; bLd[i] = 0; bMem[i] = 0;
      bA[i] = RB'(20 + i); bB[i] = RB'(24 + i); bD[i] = RB'(8 + i);
    end
  endtask

  function automatic bit readsSet(bit [31:0] s, bit [RB-1:0] r);
    return (r != 0) && s[r];
  endfunction

  // Sequential reference: walk slots oldest first.
  function automatic logic [W-1:0] model();
    bit [31:0] written = 0;
    bit memSeen = 0;
    logic [W-1:0] m = '0;
    for (int i = 0; i < W; i++) begin
      if (!bV[i]) break;
      if (readsSet(written | prevLoadSet, bA[i]) || readsSet(written | prevLoadSet, bB[i])) break;
      if (bMem[i] && memSeen) break;
      m[i] = 1'b1;
      if (bMem[i]) memSeen = 1;
      if (bWr[i] && bD[i] != 0) written[bD[i]] = 1'b1;
    end
    return m;
  endfunction

  function automatic bit expStall(logic [W-1:0] m);
    bit s = 0;
    for (int i = 0; i < W; i++) if (bV[i] && !m[i]) s = 1;
    return s;
  endfunction

  task automatic check(string req, logic [W-1:0] exp, bit es);
    checks++;
    if (issueMask !== exp || stall !== es) begin
      fails++;
      $display("FAIL %s: issueMask=%b stall=%b expected issueMask=%b stall=%b", req, issueMask, stall, exp, es);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic step(string req, output logic [W-1:0] got);
    logic [W-1:0] e;
    apply();
    #1;
    e = model();
    check(req, e, expStall(e));
    got = e;
    @(posedge clk);
    prevLoadSet = 0;
    for (int i = 0; i < W; i++)
      if (e[i] && bLd[i] && bWr[i] && bD[i] != 0) prevLoadSet[bD[i]] = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got;
    int head;
    prevLoadSet = 0;
    clearSlots();
    for (int i = 0; i < W; i++) bV[i] = 0;
    apply();
    repeat (2) @(negedge clk);
    // reset state: nothing valid, nothing issued (R8)
    check("R8 reset", '0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R10: fully independent window
    clearSlots();
    step("R1 R10 independent", got);

    // R2 R3 R4: producer slot 0 against consumer slot 1, both source ports
    for (int sel = 0; sel < 2; sel++)
      for (int d = 0; d < 4; d++)
        for (int s = 0; s < 4; s++)
          for (int wr = 0; wr < 2; wr++) begin
            clearSlots();
            bD[0] = RB'(d); bWr[0] = wr[0];
            if (sel == 0) bA[1] = RB'(s); else bB[1] = RB'(s);
            step("R2 R3 R4 pair sweep", got);
          end

    // R7 R8: every valid pattern
    for (int p = 0; p < 16; p++) begin
      clearSlots();
      for (int i = 0; i < W; i++) bV[i] = p[i];
      step("R7 R8 valid sweep", got);
    end

    // R6: every memory pattern (stores, no register writes)
    for (int p = 0; p < 16; p++) begin
      clearSlots();
      for (int i = 0; i < W; i++) begin bMem[i] = p[i]; if (p[i]) bWr[i] = 0; end
      step("R6 memory sweep", got);
    end

    // R5: load then dependent consumer, stalls once then issues
    clearSlots();
    for (int i = 1; i < W; i++) bV[i] = 0;
    bLd[0] = 1; bMem[0] = 1; bD[0] = 5;
    step("R5 load grant", got);
    clearSlots(); bA[0] = 5;
    step("R5 load-use stall", got);
    step("R5 load-use retry", got);
    // R3: load to register 0 creates no load-use stall
    clearSlots();
    for (int i = 1; i < W; i++) bV[i] = 0;
    bLd[0] = 1; bMem[0] = 1; bD[0] = 0;
    step("R3 load r0", got);
    clearSlots(); bA[0] = 0; bB[1] = 0;
    step("R3 read r0 after load", got);
    // R5: previous load in slot 2 blocks a later source on slot 3
    clearSlots(); bLd[2] = 1; bMem[2] = 1; bD[2] = 14;
    step("R5 load in slot 2", got);
    clearSlots(); bB[3] = 14;
    step("R5 dependent in slot 3", got);

    // R9: reset clears the previous-load record
    clearSlots();
    for (int i = 1; i < W; i++) bV[i] = 0;
    bLd[0] = 1; bMem[0] = 1; bD[0] = 6;
    step("R9 load before reset", got);
    rstN = 1'b0;
    @(negedge clk);
    prevLoadSet = 0;
    rstN = 1'b1;
    clearSlots(); bA[0] = 6;
    step("R9 consumer after reset", got);

    // Streaming program with re-presentation of stalled slots
    for (int n = 0; n < PROG; n++) begin
      int kind = $urandom_range(0, 9);
      pA[n] = RB'($urandom_range(0, 7));
      pB[n] = RB'($urandom_range(0, 7));
      pD[n] = RB'($urandom_range(0, 7));
      pLd[n] = (kind < 2); pMem[n] = (kind < 3); pWr[n] = (kind >= 2) || (kind < 2);
      if (kind == 2) pWr[n] = 0;
    end
    head = 0;
    while (head < PROG) begin
      for (int i = 0; i < W; i++) begin
        bV[i] = (head + i < PROG);
        if (bV[i]) begin
          bA[i] = pA[head+i]; bB[i] = pB[head+i]; bD[i] = pD[head+i];
          bWr[i] = pWr[head+i]; bLd[i] = pLd[head+i]; bMem[i] = pMem[head+i];
        end
      end
      step("R1 R2 R5 R6 R10 stream", got);
      for (int i = 0; i < W; i++) if (got[i]) head++;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule